// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a register-programmed interval timer that raises a periodic interrupt request. Software programs a divide value, a reload period and a starting count through a simple write strobe, then sets the enable bit. From then on, a prescaler divides the core clock, and each prescaler tick lowers a 32-bit down-counter by one. When the count runs out, the block sets a sticky status flag, which is also the interrupt line. In auto-reload mode it then reloads the counter from the 16-bit period register and keeps running. In one-shot mode it halts at zero and drops its own enable bit.

Any register can be read at any time through a combinational read port, and this includes the live count. Software clears the status flag by writing a one to it. A software write to the count register always overrides the timer's own update in that cycle, and it also restarts the prescaler.

Register select codes, used on both the write and the read side: 0 = control (bit 0 enable, bit 1 auto-reload), 1 = prescale, 2 = period, 3 = count, 4 = status (bit 0 interrupt flag). Every other code reads as zero and writes nothing.

Top module: `ival_timer`

## Requirements
- R1: After reset, the interrupt output is low and every register reads zero: control, prescale, period, count and status.
- R2: While enabled, a prescale value N gives exactly one counter tick every N+1 clock cycles. A value of 0 gives a tick on every cycle and 255 gives a tick every 256 cycles. The first tick falls N+1 cycles after the cycle in which the enable bit is written.
- R3: A tick lowers the count by one. While the enable bit (control bit 0) is clear, the count holds its value.
- R4: A tick taken while the count is 1 (or 0) is an expiry. An expiry sets the status flag (status bit 0), and the interrupt output goes high on the same clock edge.
- R5: At an expiry with auto-reload set (control bit 1), the count is loaded with the period register, zero-extended, and counting carries on. Only bits 15:0 of a period write are kept.
- R6: At an expiry with auto-reload clear, the count goes to zero and stays there, and control bit 0 clears itself.
- R7: The status flag stays set until software writes status with bit 0 = 1. A status write with bit 0 = 0 has no effect.
- R8: If an expiry and a status clear fall on the same edge, the flag ends up set.
- R9: A count write takes priority over a decrement or reload on the same edge. It also restarts the prescaler, so the next tick comes N+1 cycles after the write.
- R10: Each register reads back what was last written to it at its select code (prescale 8 bits, period 16 bits, control 2 bits). Unused select codes read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Register select for the read |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Interrupt request, equal to the sticky status flag |

## Verification
Two pairs of events can collide on one edge, and each pair is placed there on purpose. In the first, a status clear is lined up with the edge on which a one-shot expiry happens, and the interrupt must stay high. In the second, a count write is timed to land on a prescaler tick edge, and on an edge in the middle of a prescaler period. The count must show the written value and not a decremented or reloaded one, and the next decrement must come a full prescale period after the write.

// File: rtl/ival_pkg.sv
package ival_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      SEL_CTRL   = 3'd0,
      SEL_DIV    = 3'd1,
      SEL_PERIOD = 3'd2,
      SEL_COUNT  = 3'd3,
      SEL_STATUS = 3'd4
   } reg_sel_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_AUTO_BIT = 1;
   localparam int STAT_FLAG_BIT = 0;

endpackage

// File: rtl/ival_prescale.sv
module ival_prescale #(
   parameter int PRE_W  = 8,
   parameter bit PRE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);

   generate
      if (PRE_EN) begin : g_div
         logic [PRE_W-1:0] div_q;
         logic             wrap;

         // The >= compare keeps a shrunken limit from causing a long wrap.
         assign wrap = (div_q >= limit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run || restart || wrap)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end

         assign tick = run && !restart && wrap;
      end else begin : g_pass
         logic unused_limit;
         assign unused_limit = ^limit;
         assign tick = run && !restart;
      end
   endgenerate

endmodule

// File: rtl/ival_count.sv
module ival_count #(
   parameter int CNT_W = 32,
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             auto_en,
   input  logic [PER_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam int EXT_W = CNT_W - PER_W;

   logic [CNT_W-1:0] period_ext;
   logic             at_end;

   generate
      if (EXT_W > 0) begin : g_ext
         assign period_ext = {{EXT_W{1'b0}}, period};
      end else begin : g_same
         assign period_ext = period;
      end
   endgenerate

   assign at_end = (cnt[CNT_W-1:1] == '0);
   assign expire = tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick) begin
         if (at_end)
            cnt <= auto_en ? period_ext : '0;
         else
            cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/ival_ctrl.sv
module ival_ctrl #(
   parameter int PRE_W = 8,
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_div,
   input  logic             wr_per,
   input  logic             wr_stat,
   input  logic [1:0]       d_ctrl,
   input  logic [PRE_W-1:0] d_div,
   input  logic [PER_W-1:0] d_per,
   input  logic             d_clr,
   input  logic             expire,
   output logic             run_en,
   output logic             auto_en,
   output logic [PRE_W-1:0] div_val,
   output logic [PER_W-1:0] per_val,
   output logic             flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en  <= 1'b0;
         auto_en <= 1'b0;
      end else if (wr_ctrl) begin
         run_en  <= d_ctrl[0];
         auto_en <= d_ctrl[1];
      end else if (expire && !auto_en) begin
         run_en  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_val <= '0;
         per_val <= '0;
      end else begin
         if (wr_div) div_val <= d_div;
         if (wr_per) per_val <= d_per;
      end
   end

   // A new expiry outranks a clear on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else
         flag <= expire | (flag & ~(wr_stat & d_clr));
   end

endmodule

// File: rtl/ival_timer.sv
module ival_timer
   import ival_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 8,
   parameter int PER_W  = 16,
   parameter int DATA_W = 32,
   parameter bit PRE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   generate
      if (PER_W > CNT_W) begin : g_bad_per
         $error("ival_timer: PER_W must not exceed CNT_W");
      end
      if (CNT_W > DATA_W || PRE_W > DATA_W) begin : g_bad_data
         $error("ival_timer: DATA_W must hold the counter and prescale");
      end
      if (PRE_W < 1 || CNT_W < 2) begin : g_bad_small
         $error("ival_timer: widths too small");
      end
   endgenerate

   logic             wr_ctrl, wr_div, wr_per, wr_cnt, wr_stat;
   logic             run_en, auto_en, flag;
   logic [PRE_W-1:0] div_val;
   logic [PER_W-1:0] per_val;
   logic [CNT_W-1:0] cnt;
   logic             tick, expire;

   assign wr_ctrl = wr_en && (wr_addr == SEL_CTRL);
   assign wr_div  = wr_en && (wr_addr == SEL_DIV);
   assign wr_per  = wr_en && (wr_addr == SEL_PERIOD);
   assign wr_cnt  = wr_en && (wr_addr == SEL_COUNT);
   assign wr_stat = wr_en && (wr_addr == SEL_STATUS);

   ival_ctrl #(.PRE_W(PRE_W), .PER_W(PER_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_div  (wr_div),
      .wr_per  (wr_per),
      .wr_stat (wr_stat),
      .d_ctrl  (wr_data[CTRL_AUTO_BIT:CTRL_RUN_BIT]),
      .d_div   (wr_data[PRE_W-1:0]),
      .d_per   (wr_data[PER_W-1:0]),
      .d_clr   (wr_data[STAT_FLAG_BIT]),
      .expire  (expire),
      .run_en  (run_en),
      .auto_en (auto_en),
      .div_val (div_val),
      .per_val (per_val),
      .flag    (flag)
   );

   ival_prescale #(.PRE_W(PRE_W), .PRE_EN(PRE_EN)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .restart (wr_cnt),
      .limit   (div_val),
      .tick    (tick)
   );

   ival_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_cnt),
      .load_val (wr_data[CNT_W-1:0]),
      .auto_en  (auto_en),
      .period   (per_val),
      .cnt      (cnt),
      .expire   (expire)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         SEL_CTRL:   rd_data = DATA_W'({auto_en, run_en});
         SEL_DIV:    rd_data = DATA_W'(div_val);
         SEL_PERIOD: rd_data = DATA_W'(per_val);
         SEL_COUNT:  rd_data = DATA_W'(cnt);
         SEL_STATUS: rd_data = DATA_W'(flag);
         default:    rd_data = '0;
      endcase
   end

   assign irq = flag;

endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk
   import ival_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 8,
   parameter int PER_W  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq,
   input logic              tick,
   input logic              expire,
   input logic [CNT_W-1:0]  cnt,
   input logic              run_en,
   input logic              auto_en,
   input logic [PRE_W-1:0]  div_val,
   input logic [PER_W-1:0]  per_val
);

   logic c_cnt, c_div, c_ctrl, c_clr;
   assign c_cnt  = wr_en && (wr_addr == SEL_COUNT);
   assign c_div  = wr_en && (wr_addr == SEL_DIV);
   assign c_ctrl = wr_en && (wr_addr == SEL_CTRL);
   assign c_clr  = wr_en && (wr_addr == SEL_STATUS) && wr_data[0];

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (div_val != '0) && !c_cnt && !c_div |=> !tick);

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (cnt > CNT_W'(1)) && !c_cnt |=> cnt == $past(cnt) - 1'b1);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !c_cnt |=> cnt == $past(cnt));

   p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire && auto_en |=> cnt == CNT_W'($past(per_val)));

   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !auto_en && !c_ctrl |=> (cnt == '0) && !run_en);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !c_clr |=> irq);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && c_clr && !expire |=> !irq);

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_cnt |=> cnt == $past(wr_data[CNT_W-1:0]));

endmodule

bind ival_timer ival_timer_chk #(
   .CNT_W(CNT_W), .PRE_W(PRE_W), .PER_W(PER_W), .DATA_W(DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .irq     (irq),
   .tick    (tick),
   .expire  (expire),
   .cnt     (cnt),
   .run_en  (run_en),
   .auto_en (auto_en),
   .div_val (div_val),
   .per_val (per_val)
);

// File: tb/ival_timer_test.sv
module ival_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_PER = 3'd2,
                          A_CNT = 3'd3, A_STAT = 3'd4;

   always #10 clk = ~clk;

   ival_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic waitn(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic stop_all();
      wr(A_CTRL, 32'd0);
      wr(A_STAT, 32'd1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk("R1 reset register", v, 32'd0);
      end
      chk("R1 reset irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(A_DIV, 32'hFFFF_FFA5);  rd(A_DIV, v);  chk("R10 prescale readback", v, 32'hA5);
      wr(A_PER, 32'h0000_BEEF);  rd(A_PER, v);  chk("R10 period readback", v, 32'hBEEF);
      wr(A_CTRL, 32'd2);         rd(A_CTRL, v); chk("R10 control readback", v, 32'd2);
      wr(3'd6, 32'hFFFF_FFFF);   rd(3'd6, v);   chk("R10 unused select", v, 32'd0);
      rd(A_STAT, v); chk("R10 status readback", v, 32'd0);
      stop_all();
   endtask

   task automatic t_prescale_min();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 0); wr(A_CNT, 5); wr(A_CTRL, 1);
      waitn(1); rd(A_CNT, v); chk("R2 prescale 0 first tick", v, 32'd4);
      waitn(2); rd(A_CNT, v); chk("R3 decrement per cycle", v, 32'd2);
   endtask

   task automatic t_prescale_max();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 255); wr(A_CNT, 2); wr(A_CTRL, 1);
      waitn(255); rd(A_CNT, v); chk("R2 prescale 255 before tick", v, 32'd2);
      waitn(1);   rd(A_CNT, v); chk("R2 prescale 255 tick at 256", v, 32'd1);
   endtask

   task automatic t_hold();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 0); wr(A_CNT, 100); wr(A_CTRL, 1);
      waitn(3); rd(A_CNT, v); chk("R3 running count", v, 32'd97);
      wr(A_CTRL, 0);
      waitn(20); rd(A_CNT, v); chk("R3 disabled hold", v, 32'd96);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 1); wr(A_PER, 32'h0001_0003); wr(A_CNT, 2); wr(A_CTRL, 3);
      rd(A_PER, v); chk("R5 period upper bits dropped", v, 32'd3);
      waitn(3); rd(A_CNT, v); chk("R4 before expiry", v, 32'd1);
      chk("R4 irq low before expiry", {31'd0, irq}, 32'd0);
      waitn(1); rd(A_CNT, v); chk("R5 reload value", v, 32'd3);
      chk("R4 irq at expiry", {31'd0, irq}, 32'd1);
      rd(A_CTRL, v); chk("R5 still enabled", v, 32'd3);
      wr(A_STAT, 1);
      waitn(4); rd(A_CNT, v); chk("R5 second period count", v, 32'd1);
      chk("R7 cleared flag", {31'd0, irq}, 32'd0);
      waitn(1); rd(A_CNT, v); chk("R5 second reload", v, 32'd3);
      chk("R4 second expiry irq", {31'd0, irq}, 32'd1);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 0); wr(A_CNT, 3); wr(A_CTRL, 1);
      waitn(2); rd(A_CNT, v); chk("R6 before end", v, 32'd1);
      waitn(1); rd(A_CNT, v); chk("R6 stops at zero", v, 32'd0);
      rd(A_CTRL, v); chk("R6 enable self-clears", v, 32'd0);
      chk("R4 one-shot irq", {31'd0, irq}, 32'd1);
      waitn(5); rd(A_CNT, v); chk("R6 stays zero", v, 32'd0);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 0); wr(A_CNT, 1); wr(A_CTRL, 1);
      waitn(1); chk("R4 flag set", {31'd0, irq}, 32'd1);
      waitn(10); chk("R7 flag sticky", {31'd0, irq}, 32'd1);
      wr(A_STAT, 0); chk("R7 write zero ignored", {31'd0, irq}, 32'd1);
      wr(A_STAT, 1); chk("R7 write one clears", {31'd0, irq}, 32'd0);
      rd(A_STAT, v); chk("R7 status reads clear", v, 32'd0);
   endtask

   task automatic t_setwins();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 0); wr(A_CNT, 1); wr(A_CTRL, 1);
      waitn(1); chk("R8 flag preset", {31'd0, irq}, 32'd1);
      wr(A_CNT, 4); wr(A_CTRL, 1);
      waitn(3); rd(A_CNT, v); chk("R8 count before collision", v, 32'd1);
      wr(A_STAT, 1);
      chk("R8 set wins over clear", {31'd0, irq}, 32'd1);
      rd(A_CNT, v); chk("R8 expiry happened", v, 32'd0);
   endtask

   task automatic t_cntwrite();
      logic [31:0] v;
      stop_all(); wr(A_DIV, 3); wr(A_PER, 50); wr(A_CNT, 10); wr(A_CTRL, 3);
      waitn(1);
      wr(A_CNT, 5);
      waitn(3); rd(A_CNT, v); chk("R9 prescaler restarted", v, 32'd5);
      waitn(1); rd(A_CNT, v); chk("R9 first tick after write", v, 32'd4);
      waitn(3);
      wr(A_CNT, 7);
      rd(A_CNT, v); chk("R9 write beats tick", v, 32'd7);
      waitn(3); rd(A_CNT, v); chk("R9 hold after write", v, 32'd7);
      waitn(1); rd(A_CNT, v); chk("R9 tick after write", v, 32'd6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regmap();
      t_prescale_min();
      t_prescale_max();
      t_hold();
      t_reload();
      t_oneshot();
      t_sticky();
      t_setwins();
      t_cntwrite();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule